// File: doc/BRIEF.md
# Masked Level/Event Interrupt Aggregator

This block gathers up to 31 device interrupt request lines into one CPU interrupt output. It holds three 32-bit registers: an enable mask, a mirror of the present line levels, and a set of latched events. It also decodes a write-only clear register. Each clock it compares the incoming lines against the stored levels. Every line that changed may set or drop its event bit. The events register is then filtered by the mask. A sticky latch drives the CPU interrupt while any event is pending.

Bit 31 of the mask selects the capture mode. With it clear, an event is captured only when a line rises, and a falling line drops its event. With it set, any change on a line captures an event. The same bit position in clear-register data acts as a clear-all command, but only in change mode. Software reaches the registers over a plain single-cycle register port. Write data on that port arrives byte-reversed and is swapped back inside the block. Reads are combinational from the address. This is a control interface with no flow control, so it has no valid/ready pair: a write takes effect on the edge where `reg_wr` is sampled high.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the events, mask and levels registers read zero and `cpu_irq` is low.
- R2: Reads decode only address bits above the low two. Events are at 0x00, mask at 0x04 and levels at 0x0C. The clear register at 0x08 and every other offset read zero. Bit 31 of events and of levels always reads zero.
- R3: A write is accepted only at exactly 0x04 (mask) or 0x08 (clear), and a write to any other address changes nothing. The 32-bit write data is byte-reversed before use: bus byte 0 becomes register bits 31:24, and so on down.
- R4: The levels register shows each line's state (1 = high) one clock after it is sampled.
- R5: With mask bit 31 clear (edge mode), a 0-to-1 line transition sets that line's event bit, and a 1-to-0 transition clears it.
- R6: With mask bit 31 set (change mode), any transition on a line sets that line's event bit.
- R7: In a cycle where any line changes, the updated events are ANDed with the mask, so a masked line never holds an event. A mask write on its own leaves the events register unchanged.
- R8: A clear write with mask bit 31 set and (swapped) data bit 31 set zeroes all events. Any other clear write clears exactly the event bits in 30:0 whose data bit is 1.
- R9: `cpu_irq` is asserted in the same cycle that the events register becomes nonzero. It stays asserted when line activity later returns the events to zero.
- R10: `cpu_irq` is released only on a clear write after which the events register is zero. A clear write that leaves any event pending keeps it asserted.
- R11: Changes on several lines in the same cycle are all captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data, byte-reversed on the bus |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_lines | input | 31 | Device interrupt request lines |
| cpu_irq | output | 1 | Latched CPU interrupt |

## Verification
On every cycle, the assertions check that a pending event always keeps `cpu_irq` high and that the latch never falls without a clear write. They also check that a cycle with line changes leaves no event outside the mask. In edge mode a falling line must leave no event behind, and in change mode every masked line that changed must hold an event. Byte-lane swapping, address decode, the clear-all rule that applies only in change mode, and the sticky latch surviving a falling line are shown by the bench's directed scenarios. Each of these needs a specific order of register writes and line activity.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_W    = 32;
  localparam int MODE_BIT = 31;
  localparam int ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] OFF_EVENTS = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_LEVELS = 8'h0C;

  // Bits a per-bit clear may touch: everything except the mode/clear-all bit.
  localparam logic [REG_W-1:0] PERBIT_CLR_MASK = ~(REG_W'(1) << MODE_BIT);

  function automatic logic [REG_W-1:0] byte_reverse(input logic [REG_W-1:0] d);
    logic [REG_W-1:0] r;
    for (int b = 0; b < REG_W/8; b++) begin
      r[8*b +: 8] = d[REG_W-8-8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/irqagg_regif.sv
module irqagg_regif
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  evt_q,
  input  logic [REG_W-1:0]  lvl_q,
  output logic [REG_W-1:0]  mask_q,
  output logic              clr_fire,
  output logic [REG_W-1:0]  clr_data,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int WORD_MSB = ADDR_W - 1;

  logic [REG_W-1:0] wdata_sw;
  logic             mask_fire;
  logic [WORD_MSB-2:0] word_idx;

  assign wdata_sw  = byte_reverse(reg_wdata);
  assign mask_fire = reg_wr && (reg_addr == OFF_MASK);
  assign clr_fire  = reg_wr && (reg_addr == OFF_CLEAR);
  assign clr_data  = wdata_sw;
  assign word_idx  = reg_addr[WORD_MSB:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_fire) begin
      mask_q <= wdata_sw;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (word_idx == OFF_EVENTS[WORD_MSB:2]) begin
      reg_rdata = evt_q;
    end else if (word_idx == OFF_MASK[WORD_MSB:2]) begin
      reg_rdata = mask_q;
    end else if (word_idx == OFF_LEVELS[WORD_MSB:2]) begin
      reg_rdata = lvl_q;
    end
  end
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [REG_W-1:0]     mask_q,
  input  logic                 clr_fire,
  input  logic [REG_W-1:0]     clr_data,
  output logic [REG_W-1:0]     evt_q,
  output logic [REG_W-1:0]     evt_next,
  output logic [REG_W-1:0]     lvl_q,
  output logic [NUM_LINES-1:0] line_chg
);
  logic             mode_any;
  logic [REG_W-1:0] evt_upd;
  logic [REG_W-1:0] evt_line;
  logic [REG_W-1:0] lvl_next;

  assign mode_any = mask_q[MODE_BIT];

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < NUM_LINES) begin : g_line
      assign line_chg[i] = lines[i] ^ lvl_q[i];
      assign evt_upd[i]  = line_chg[i] ? (mode_any | lines[i]) : evt_q[i];
      assign lvl_next[i] = lines[i];
    end else begin : g_pad
      assign evt_upd[i]  = evt_q[i];
      assign lvl_next[i] = 1'b0;
    end
  end

  assign evt_line = (|line_chg) ? (evt_upd & mask_q) : evt_q;

  always_comb begin
    evt_next = evt_line;
    if (clr_fire) begin
      if (mode_any && clr_data[MODE_BIT]) begin
        evt_next = '0;
      end else begin
        evt_next = evt_line & ~(clr_data & PERBIT_CLR_MASK);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      lvl_q <= '0;
    end else begin
      evt_q <= evt_next;
      lvl_q <= lvl_next;
    end
  end
endmodule

// File: rtl/irqagg_latch.sv
module irqagg_latch
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_next,
  input  logic             clr_fire,
  output logic             irq_q
);
  logic pending;
  assign pending = |evt_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (pending) begin
      irq_q <= 1'b1;
    end else if (clr_fire) begin
      irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 cpu_irq
);
  logic [REG_W-1:0]     mask_q;
  logic [REG_W-1:0]     evt_q;
  logic [REG_W-1:0]     evt_next;
  logic [REG_W-1:0]     lvl_q;
  logic [REG_W-1:0]     clr_data;
  logic                 clr_fire;
  logic [NUM_LINES-1:0] line_chg;

  irqagg_regif #(.NUM_LINES(NUM_LINES)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_q(evt_q), .lvl_q(lvl_q), .mask_q(mask_q),
    .clr_fire(clr_fire), .clr_data(clr_data), .reg_rdata(reg_rdata)
  );

  irqagg_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .mask_q(mask_q),
    .clr_fire(clr_fire), .clr_data(clr_data), .evt_q(evt_q),
    .evt_next(evt_next), .lvl_q(lvl_q), .line_chg(line_chg)
  );

  irqagg_latch u_latch (
    .clk(clk), .rst_n(rst_n), .evt_next(evt_next), .clr_fire(clr_fire),
    .irq_q(cpu_irq)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_irq,
  input logic                 clr_fire,
  input logic [REG_W-1:0]     evt_q,
  input logic [REG_W-1:0]     mask_q,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [NUM_LINES-1:0] line_chg
);
  p_pending_drives_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != '0) |-> cpu_irq);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !clr_fire) |=> cpu_irq);

  p_masked_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_chg) |=> ((evt_q & ~$past(mask_q)) == '0));

  p_fall_drops_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[MODE_BIT] && (|line_chg))
      |=> ((evt_q[NUM_LINES-1:0] & $past(line_chg & ~irq_lines)) == '0));

  p_change_sets_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[MODE_BIT] && !clr_fire)
      |=> (($past(line_chg) & $past(mask_q[NUM_LINES-1:0]) & ~evt_q[NUM_LINES-1:0]) == '0));

  p_top_bit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q[MODE_BIT]);
endmodule

bind irq_aggregator irqagg_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .clr_fire(clr_fire),
  .evt_q(evt_q), .mask_q(mask_q), .irq_lines(irq_lines), .line_chg(line_chg)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int NL = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic        cpu_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] swp(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = swp(v);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] busv);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = busv;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 events", 8'h00, 32'h0);
    rd_chk("R1 mask", 8'h04, 32'h0);
    rd_chk("R1 levels", 8'h0C, 32'h0);
    rd_chk("R2 clear reads 0", 8'h08, 32'h0);
    check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_decode;
    wr(8'h04, 32'h0000_000F);
    rd_chk("R3 swapped mask", 8'h04, 32'h0000_000F);
    rd_chk("R2 low bits ignored", 8'h07, 32'h0000_000F);
    wr(8'h06, 32'h1234_5678);
    rd_chk("R3 misaligned write ignored", 8'h04, 32'h0000_000F);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R3 unmapped write ignored", 8'h04, 32'h0000_000F);
    rd_chk("R2 unmapped read", 8'h10, 32'h0);
    wr_raw(8'h04, 32'h0F00_0000);
    rd_chk("R3 byte lane order", 8'h04, 32'h0000_000F);
  endtask

  task automatic t_edge;
    set_lines(31'h1);
    rd_chk("R5 rise sets event", 8'h00, 32'h1);
    rd_chk("R4 levels high", 8'h0C, 32'h1);
    check("R9 irq on event", {31'b0, cpu_irq}, 32'h1);
    set_lines(31'h0);
    rd_chk("R5 fall clears event", 8'h00, 32'h0);
    rd_chk("R4 levels low", 8'h0C, 32'h0);
    check("R9 irq sticky", {31'b0, cpu_irq}, 32'h1);
    wr(8'h08, 32'h0);
    check("R10 release on clear when empty", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_masked_and_multi;
    set_lines(31'h100);
    rd_chk("R7 masked line no event", 8'h00, 32'h0);
    rd_chk("R4 masked line level", 8'h0C, 32'h100);
    check("R7 no irq", {31'b0, cpu_irq}, 32'h0);
    set_lines(31'h106);
    rd_chk("R11 two lines at once", 8'h00, 32'h6);
    wr(8'h08, 32'h2);
    rd_chk("R8 per-bit clear", 8'h00, 32'h4);
    check("R10 irq kept while pending", {31'b0, cpu_irq}, 32'h1);
    wr(8'h08, 32'h4);
    check("R10 irq released", {31'b0, cpu_irq}, 32'h0);
    set_lines(31'h0);
    rd_chk("R5 falls add nothing", 8'h00, 32'h0);
  endtask

  task automatic t_change_mode;
    wr(8'h04, 32'h8000_000F);
    set_lines(31'h8);
    rd_chk("R6 rise in change mode", 8'h00, 32'h8);
    wr(8'h08, 32'h8000_0000);
    rd_chk("R8 clear-all", 8'h00, 32'h0);
    check("R10 clear-all releases", {31'b0, cpu_irq}, 32'h0);
    set_lines(31'h0);
    rd_chk("R6 fall sets event", 8'h00, 32'h8);
    check("R9 irq on fall event", {31'b0, cpu_irq}, 32'h1);
    wr(8'h08, 32'h8000_0000);
    check("R10 released", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_clear_all_edge;
    wr(8'h04, 32'h0000_000F);
    set_lines(31'h1);
    wr(8'h08, 32'h8000_0000);
    rd_chk("R8 clear-all ignored in edge mode", 8'h00, 32'h1);
    check("R10 irq kept", {31'b0, cpu_irq}, 32'h1);
    wr(8'h04, 32'h0000_0000);
    rd_chk("R7 mask write keeps events", 8'h00, 32'h1);
    set_lines(31'h5);
    rd_chk("R7 change applies mask", 8'h00, 32'h0);
    check("R9 irq still latched", {31'b0, cpu_irq}, 32'h1);
    wr(8'h08, 32'h0);
    check("R10 clear with empty events", {31'b0, cpu_irq}, 32'h0);
    set_lines(31'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_edge();
    t_masked_and_multi();
    t_change_mode();
    t_clear_all_edge();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule